// File: doc/BRIEF.md
# Header-Based Packet Class Counter

This block watches a byte-wide packet stream and sorts each packet into a traffic class using only its leading header bytes. The stream carries a valid strobe, a start-of-packet flag and an end-of-packet flag, and its first byte is the first byte of the network-layer header. Every completed packet adds one to a total counter and one to exactly one class counter. The classes are: web over TCP/IPv4, other TCP/IPv4, UDP/IPv4, IPv6, and everything else.

For IPv4 the transport header can start at a variable offset, because the header length field sets where it begins. The parser therefore tracks the byte index inside each packet and finds the port fields relative to that offset. The class is settled as soon as the fields it needs have arrived. It is committed to the counters on the end-of-packet beat.

A registered read port returns any counter one cycle after a read request. A synchronous clear input zeroes all counters at once. Counters stop at their maximum value rather than wrapping.

Top module: `pkt_class_counter`

## Requirements
- R1: The upper nibble of byte 0 selects the IP version. A value of 4 sends the packet into IPv4 parsing. A value of 6 puts the packet in the IPv6 class whatever follows. Any other value puts it in the other class.
- R2: An IPv4 packet whose byte at offset 9 equals 17 is counted in the UDP class.
- R3: An IPv4 packet whose byte at offset 9 equals 6 is web traffic when its source port or its destination port equals 80. The transport header starts at byte IHL×4, where IHL is the lower nibble of byte 0. The source port is the two bytes at transport offsets 0 and 1, high byte first. The destination port is the two bytes at transport offsets 2 and 3, high byte first.
- R4: A TCP/IPv4 packet in which neither port equals 80 is counted in the other-TCP class.
- R5: The packet is counted in the other class in any of these cases: the IPv4 protocol byte is neither 6 nor 17; IHL is below 5; or the packet ends before the bytes needed to decide its class have arrived.
- R6: Each packet is counted exactly once, on its end-of-packet beat. That beat increments the total counter and the counter of the packet's class.
- R7: A read request at rd_addr_i returns data with rd_valid_o high on the next cycle. The addresses are: 0 total, 1 web, 2 other TCP, 3 UDP, 4 IPv6, 5 other. Addresses 6 and 7 read as zero. A read in the same cycle as an increment returns the value before the increment.
- R8: A counter at its all-ones maximum stays there when further packets of its class arrive.
- R9: clear_i zeroes every counter on the next cycle. It takes precedence over an increment in the same cycle.
- R10: A beat with valid high that is neither a start-of-packet nor inside a packet begun by one is ignored. It changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_valid_i | input | 1 | Stream byte valid |
| s_sop_i | input | 1 | First byte of a packet |
| s_eop_i | input | 1 | Last byte of a packet |
| s_data_i | input | 8 | Stream byte |
| clear_i | input | 1 | Synchronous clear of all counters |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 3 | Counter select |
| rd_data_o | output | CNT_W | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |

## Verification
A parser that miscounts the byte index, or that keeps a stale header length, puts a packet in the wrong class. This shows up at the ports as one class counter too high and another too low on the next read, while the total stays correct. To catch such errors, the bench places port bytes at different offsets, uses ports whose high and low bytes are swapped, and sends packets that end one byte short of a decision. Faults in the counters themselves (a broken clear, saturation or read timing) show as read data that is off on the very next read. A scoreboard predicts every read value from a model of the requirements.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_WEB   = 3'd1,
    CLS_TCP   = 3'd2,
    CLS_UDP   = 3'd3,
    CLS_V6    = 3'd4,
    CLS_OTHER = 3'd5
  } cls_e;

  localparam int unsigned NUM_CNT   = 6;
  localparam int unsigned IDX_TOTAL = 0;
  localparam logic [3:0]  VER_V4    = 4'd4;
  localparam logic [3:0]  VER_V6    = 4'd6;
  localparam logic [3:0]  MIN_IHL   = 4'd5;
  localparam logic [7:0]  PROTO_TCP = 8'd6;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam logic [15:0] WEB_PORT  = 16'd80;
endpackage

// File: rtl/pcc_parser.sv
module pcc_parser
  import pcc_pkg::*;
#(
  parameter int unsigned IDX_W = 7,
  parameter logic [15:0] PORT  = WEB_PORT
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic       sop_i,
  input  logic       eop_i,
  input  logic [7:0] data_i,
  output logic       evt_o,
  output cls_e       evt_cls_o
);
  localparam logic [IDX_W-1:0] IDX_MAX   = '1;
  localparam logic [IDX_W-1:0] IDX_PROTO = IDX_W'(9);

  logic [IDX_W-1:0] idx_q, cur_idx;
  logic [IDX_W-1:0] tp0, tp1, tp2, tp3;
  logic             in_pkt_q, decided_q, web_q;
  cls_e             cls_q;
  logic [3:0]       ihl_q;
  logic [7:0]       hi_q;

  logic beat, active, dec_now, web_now;
  cls_e cls_now;

  assign beat    = valid_i && (sop_i || in_pkt_q);
  assign active  = beat && (sop_i || !decided_q);
  assign cur_idx = sop_i ? '0 : idx_q;

  // transport header offsets
  assign tp0 = IDX_W'({ihl_q, 2'b00});
  assign tp1 = tp0 + IDX_W'(1);
  assign tp2 = tp0 + IDX_W'(2);
  assign tp3 = tp0 + IDX_W'(3);

  always_comb begin
    dec_now = 1'b0;
    cls_now = CLS_OTHER;
    web_now = 1'b0;
    if (active) begin
      if (cur_idx == '0) begin
        if (data_i[7:4] == VER_V6) begin
          dec_now = 1'b1;
          cls_now = CLS_V6;
        end else if (data_i[7:4] != VER_V4 || data_i[3:0] < MIN_IHL) begin
          dec_now = 1'b1;
          cls_now = CLS_OTHER;
        end
      end else if (cur_idx == IDX_PROTO) begin
        if (data_i == PROTO_UDP) begin
          dec_now = 1'b1;
          cls_now = CLS_UDP;
        end else if (data_i != PROTO_TCP) begin
          dec_now = 1'b1;
          cls_now = CLS_OTHER;
        end
      end else if (cur_idx == tp1) begin
        web_now = ({hi_q, data_i} == PORT);
      end else if (cur_idx == tp3) begin
        dec_now = 1'b1;
        cls_now = (web_q || {hi_q, data_i} == PORT) ? CLS_WEB : CLS_TCP;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      in_pkt_q  <= 1'b0;
      decided_q <= 1'b0;
      web_q     <= 1'b0;
      cls_q     <= CLS_OTHER;
      ihl_q     <= '0;
      hi_q      <= '0;
    end else if (beat) begin
      in_pkt_q <= !eop_i;
      if (sop_i)                 idx_q <= IDX_W'(1);
      else if (idx_q != IDX_MAX) idx_q <= idx_q + IDX_W'(1);
      if (cur_idx == '0) ihl_q <= data_i[3:0];
      if (sop_i)        decided_q <= dec_now;
      else if (dec_now) decided_q <= 1'b1;
      if (dec_now) cls_q <= cls_now;
      if (sop_i)        web_q <= 1'b0;
      else if (web_now) web_q <= 1'b1;
      if (cur_idx == tp0 || cur_idx == tp2) hi_q <= data_i;
    end
  end

  assign evt_o     = beat && eop_i;
  assign evt_cls_o = (decided_q && !sop_i) ? cls_q :
                     (dec_now ? cls_now : CLS_OTHER);

  p_cls_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decided_q && !(valid_i && sop_i)) |=> (cls_q == $past(cls_q)));

  p_evt_class_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (evt_cls_o != CLS_NONE));

  p_evt_on_eop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (valid_i && eop_i));

  p_web_needs_tcp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (decided_q && cls_q == CLS_WEB) |-> (ihl_q >= MIN_IHL));
endmodule

// File: rtl/pcc_counter_bank.sv
module pcc_counter_bank
  import pcc_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned NUM   = NUM_CNT,
  parameter int unsigned AW    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             evt_i,
  input  cls_e             evt_cls_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM];
  logic [CNT_W-1:0] rd_mux;

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic inc;
    if (g == IDX_TOTAL) begin : g_total
      assign inc = evt_i;
    end else begin : g_class
      assign inc = evt_i && (evt_cls_i == cls_e'(g));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     cnt_q[g] <= '0;
      else if (clear_i)                cnt_q[g] <= '0;
      else if (inc && cnt_q[g] != CNT_MAX) cnt_q[g] <= cnt_q[g] + CNT_W'(1);
    end

    p_sat_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clear_i && cnt_q[g] == CNT_MAX) |=> (cnt_q[g] == CNT_MAX));

    p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clear_i |=> (cnt_q[g] == '0));

    if (g != IDX_TOTAL) begin : g_bound
      p_class_le_total_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q[g] <= cnt_q[IDX_TOTAL]);
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM; i++) begin
      if (rd_addr_i == AW'(i)) rd_mux = cnt_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end

  p_total_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && evt_i && cnt_q[IDX_TOTAL] != CNT_MAX)
      |=> (cnt_q[IDX_TOTAL] == $past(cnt_q[IDX_TOTAL]) + CNT_W'(1)));

  p_rd_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  p_rd_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

// File: rtl/pkt_class_counter.sv
module pkt_class_counter
  import pcc_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             s_valid_i,
  input  logic             s_sop_i,
  input  logic             s_eop_i,
  input  logic [7:0]       s_data_i,
  input  logic             clear_i,
  input  logic             rd_en_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  logic evt;
  cls_e evt_cls;

  pcc_parser #(
    .IDX_W (IDX_W),
    .PORT  (WEB_PORT)
  ) u_parser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (s_valid_i),
    .sop_i     (s_sop_i),
    .eop_i     (s_eop_i),
    .data_i    (s_data_i),
    .evt_o     (evt),
    .evt_cls_o (evt_cls)
  );

  pcc_counter_bank #(
    .CNT_W (CNT_W),
    .NUM   (NUM_CNT),
    .AW    (3)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .evt_i      (evt),
    .evt_cls_i  (evt_cls),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );
endmodule

// File: tb/pkt_class_counter_bench.sv
module pkt_class_counter_bench;
  localparam int CW   = 5;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni;
  logic          s_valid_i, s_sop_i, s_eop_i, clear_i, rd_en_i;
  logic [7:0]    s_data_i;
  logic [2:0]    rd_addr_i;
  logic [CW-1:0] rd_data_o;
  logic          rd_valid_o;

  always #5 clk_i = ~clk_i;

  pkt_class_counter #(.CNT_W(CW)) u_pkt_class_counter (
    .clk_i, .rst_ni, .s_valid_i, .s_sop_i, .s_eop_i, .s_data_i,
    .clear_i, .rd_en_i, .rd_addr_i, .rd_data_o, .rd_valid_o
  );

  typedef struct { int exp; string tag; } item_t;
  item_t sb[$];
  int model [8];
  logic [7:0] pkt [128];
  int plen;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  function automatic int sat_inc(int v);
    return (v >= MAXV) ? MAXV : v + 1;
  endfunction

  // monitor: pops expected read values
  always @(negedge clk_i) begin
    item_t it;
    if (rd_valid_o) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_err++;
        $display("FAIL R7: unexpected read data got %0d expected none", rd_data_o);
      end else begin
        it = sb.pop_front();
        if (int'(rd_data_o) != it.exp) begin
          n_err++;
          $display("FAIL %s: got %0d expected %0d", it.tag, rd_data_o, it.exp);
        end
      end
    end
  end

  task automatic build_v4(int ihl, int proto, int sp, int dp, int len);
    int t;
    plen = len;
    for (int i = 0; i < 128; i++) pkt[i] = 8'h11;
    pkt[0] = {4'd4, 4'(ihl)};
    pkt[9] = 8'(proto);
    t = ihl * 4;
    pkt[t]   = 8'(sp >> 8);
    pkt[t+1] = 8'(sp);
    pkt[t+2] = 8'(dp >> 8);
    pkt[t+3] = 8'(dp);
  endtask

  task automatic build_raw(logic [7:0] first, int len);
    plen = len;
    for (int i = 0; i < 128; i++) pkt[i] = 8'h00;
    pkt[0] = first;
  endtask

  // cls<0: no count; rd_a>=0: read on last beat; clr: clear on last beat
  task automatic send(int cls, int rd_a, bit clr, bit with_sop, string tag);
    for (int i = 0; i < plen; i++) begin
      @(negedge clk_i);
      s_valid_i = 1'b1;
      s_sop_i   = with_sop && (i == 0);
      s_eop_i   = (i == plen - 1);
      s_data_i  = pkt[i];
      if (i == plen - 1) begin
        if (rd_a >= 0) begin
          rd_en_i   = 1'b1;
          rd_addr_i = 3'(rd_a);
          sb.push_back('{model[rd_a], tag});
        end
        if (clr) clear_i = 1'b1;
      end
    end
    @(negedge clk_i);
    s_valid_i = 1'b0; s_sop_i = 1'b0; s_eop_i = 1'b0;
    rd_en_i = 1'b0; clear_i = 1'b0;
    if (clr) begin
      foreach (model[k]) model[k] = 0;
    end else if (cls > 0) begin
      model[0]   = sat_inc(model[0]);
      model[cls] = sat_inc(model[cls]);
    end
  endtask

  task automatic rd(int a, string tag);
    @(negedge clk_i);
    rd_en_i   = 1'b1;
    rd_addr_i = 3'(a);
    sb.push_back('{model[a], tag});
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic check_all(string tag);
    for (int a = 0; a < 8; a++) rd(a, tag);
  endtask

  task automatic clear_pulse();
    @(negedge clk_i);
    clear_i = 1'b1;
    @(negedge clk_i);
    clear_i = 1'b0;
    foreach (model[k]) model[k] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R6: watchdog got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    foreach (model[k]) model[k] = 0;
    rst_ni = 1'b0; s_valid_i = 0; s_sop_i = 0; s_eop_i = 0; s_data_i = 0;
    clear_i = 0; rd_en_i = 0; rd_addr_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    n_chk++;
    if (rd_valid_o !== 1'b0) begin
      n_err++;
      $display("FAIL R7: rd_valid_o after reset got %0b expected 0", rd_valid_o);
    end
    check_all("R7 reset");

    build_v4(5, 6, 1234, 80, 40);       send(1, -1, 0, 1, "");  // R3 dst port
    build_v4(7, 6, 80, 5555, 40);       send(1, -1, 0, 1, "");  // R3 src port, options
    build_v4(5, 6, 16'h5000, 16'h1F90, 24); send(2, -1, 0, 1, ""); // R4 byte order
    build_v4(5, 17, 80, 80, 12);        send(3, -1, 0, 1, "");  // R2
    build_raw(8'h60, 8);                send(4, -1, 0, 1, "");  // R1 v6
    build_raw(8'h6F, 1);                send(4, -1, 0, 1, "");  // R1 single beat
    build_raw(8'h55, 30);               send(5, -1, 0, 1, "");  // R1 version 5
    build_v4(5, 1, 80, 80, 30);         send(5, -1, 0, 1, "");  // R5 protocol
    build_v4(3, 6, 80, 80, 30);         send(5, -1, 0, 1, "");  // R5 IHL<5
    build_v4(5, 6, 80, 80, 23);         send(5, -1, 0, 1, "");  // R5 truncated
    build_v4(5, 6, 80, 1, 8);           send(5, -1, 0, 1, "");  // R5 before proto
    check_all("R1 R2 R3 R4 R5 R6 classes");

    build_v4(5, 6, 80, 80, 40);         send(-1, -1, 0, 0, ""); // R10 stray
    check_all("R10 stray beats");

    build_v4(5, 17, 1, 2, 12);          send(3, 0, 0, 1, "R7 read with increment");
    check_all("R7 R6 after increment");

    clear_pulse();
    check_all("R9 clear");
    build_v4(5, 6, 80, 80, 30);         send(1, -1, 0, 1, "");
    build_v4(5, 17, 1, 2, 12);          send(3, -1, 1, 1, "");  // R9 clear wins
    check_all("R9 clear over increment");

    for (int n = 0; n < MAXV + 2; n++) begin
      build_v4(5, 17, 7, 7, 10);
      send(3, -1, 0, 1, "");
    end
    check_all("R8 saturation");

    repeat (4) @(negedge clk_i);
    n_chk++;
    if (sb.size() != 0) begin
      n_err++;
      $display("FAIL R7: pending reads got %0d expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule